// File: doc/BRIEF.md
# Open-Page DRAM Access Controller

This block connects a processor-side request port to a small DRAM that has a single set of multiplexed address pins. Each request carries a word address and a write flag, plus write data when the flag is set. The block splits the address into a row number and a column number. It then drives the row on the pins with the row strobe, which loads the whole row into the memory's internal row buffer. After that it drives the column with the column strobe, which moves one supercell between the row buffer and the data lines.

The block keeps the most recently opened row active. A later access that falls in the same row skips the row phase and issues only a column strobe. An access to a different row first issues a close strobe, which writes the row buffer back to the array, and only then opens the new row.

A free-running timer requests a refresh at a fixed interval. A refresh opens one row and closes it again, and successive refreshes step through the rows in turn. A pending refresh blocks new requests and closes any open row before it starts. Every strobe phase lasts a configurable number of clock cycles.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, all three strobes are 0, `rsp_valid` is 0, and no row is open.
- R2: The request address is split into a row, taken from the upper PIN_W bits, and a column, taken from the lower PIN_W bits. `dr_addr` carries the row while `dr_row_stb` is high and the column while `dr_col_stb` is high.
- R3: When no row is open, a read issues one row phase followed by one column phase. `rsp_valid` rises 2*PHASE_CYC clock edges after the accepting edge.
- R4: An access to the row that is already open issues no row or close strobe, only a column phase. A read of this kind completes PHASE_CYC edges after acceptance.
- R5: An access to a row other than the open one issues a close phase, then a row phase, then a column phase, so a read completes after 3*PHASE_CYC edges. Data written into the closed row is kept and reads back later.
- R6: Every strobe phase holds its strobe high for exactly PHASE_CYC cycles. `req_ready` stays 0 from acceptance until the access finishes.
- R7: A read returns the addressed supercell on `rsp_rdata` with a `rsp_valid` pulse one cycle long. A write produces no `rsp_valid`.
- R8: A write changes only the addressed supercell of the row buffer. Later reads of that address return the new value, and other addresses keep their old values.
- R9: A refresh happens every REF_INTERVAL cycles. Each refresh is one row phase followed by one close phase, and the refreshed row steps 0, 1, ..., ROWS-1 and then wraps to 0.
- R10: A pending refresh holds `req_ready` at 0 and closes any open row before its own row phase. After the refresh no row is open, so the next access issues a row strobe.
- R11: At most one of `dr_row_stb`, `dr_col_stb` and `dr_close` is high in any cycle, and `dr_addr` does not change while a row or column strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 2*PIN_W | Word address: row in the upper half, column in the lower half |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse when read data is valid |
| rsp_rdata | output | DATA_W | Read data |
| dr_addr | output | PIN_W | Multiplexed row/column address pins |
| dr_row_stb | output | 1 | Row strobe: opens the row on `dr_addr` into the row buffer |
| dr_col_stb | output | 1 | Column strobe: selects the supercell on `dr_addr` |
| dr_close | output | 1 | Close strobe: writes the row buffer back to the array |
| dr_we | output | 1 | Column access is a write |
| dr_wdata | output | DATA_W | Data for a column write |
| dr_rdata | input | DATA_W | Supercell from the row buffer at `dr_addr` |

## Verification
The assertions take three things for granted about the inputs. First, the memory's `dr_rdata` reflects its row buffer at `dr_addr` within the same cycle. Second, reset is held for at least one clock edge. Third, request fields are stable whenever `req_valid` is high. The bench drives requests only at falling edges after it has seen `req_ready` high, and drops `req_valid` right after the accepting edge. Its memory model acts only on the rising edge of each strobe, which lets the strobe sequence and the write-back behaviour be observed directly at the pins.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ACT  = 3'd2,
        ST_COL  = 3'd3,
        ST_RACT = 3'd4,
        ST_RPRE = 3'd5
    } dctl_state_e;

endpackage

// File: rtl/pgdram_phase_timer.sv
module pgdram_phase_timer #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [PW-1:0] LAST_CNT = PW'(PHASE_CYC - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart)
            cnt_d = '0;
        else if (cnt_q == LAST_CNT)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last = (cnt_q == LAST_CNT);

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !last) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6

endmodule

// File: rtl/pgdram_refresh.sv
module pgdram_refresh #(
    parameter int REF_INTERVAL = 1560,
    parameter int ROW_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int CW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [CW-1:0] WRAP = CW'(REF_INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (ack) begin
            rf_d.pend = 1'b0;
            rf_d.row  = rf_q.row + 1'b1;
        end
        if (rf_q.cnt == WRAP) begin
            rf_d.cnt  = '0;
            rf_d.pend = 1'b1;
        end else begin
            rf_d.cnt = rf_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rf_q <= '0;
        else
            rf_q <= rf_d;
    end

    assign pending = rf_q.pend;
    assign row     = rf_q.row;

    AST_REF_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (row == $past(row) + 1'b1)); // R9
    AST_REF_ACK_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pending); // R10

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int PIN_W        = 2,
    parameter int DATA_W       = 8,
    parameter int PHASE_CYC    = 2,
    parameter int REF_INTERVAL = 1560
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2*PIN_W-1:0]   req_addr,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [PIN_W-1:0]     dr_addr,
    output logic                 dr_row_stb,
    output logic                 dr_col_stb,
    output logic                 dr_close,
    output logic                 dr_we,
    output logic [DATA_W-1:0]    dr_wdata,
    input  logic [DATA_W-1:0]    dr_rdata
);
    localparam int ADDR_W = 2 * PIN_W;

    typedef struct packed {
        dctl_state_e      st;
        logic             open;
        logic [PIN_W-1:0] open_row;
        logic [PIN_W-1:0] row;
        logic [PIN_W-1:0] col;
        logic [PIN_W-1:0] rrow;
        logic             wr;
        logic [DATA_W-1:0] wdata;
        logic             in_ref;
        logic             rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             ph_last;
    logic             ph_restart;
    logic             ref_pend;
    logic             ref_ack;
    logic [PIN_W-1:0] ref_row;
    logic [PIN_W-1:0] in_row;
    logic [PIN_W-1:0] in_col;

    assign in_row = req_addr[ADDR_W-1:PIN_W];
    assign in_col = req_addr[PIN_W-1:0];

    pgdram_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ph_restart),
        .last    (ph_last)
    );

    pgdram_refresh #(
        .REF_INTERVAL (REF_INTERVAL),
        .ROW_W        (PIN_W)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pend),
        .row     (ref_row)
    );

    always_comb begin
        c_d           = c_q;
        c_d.rsp_valid = 1'b0;
        ref_ack       = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_ack    = 1'b1;
                    c_d.rrow   = ref_row;
                    c_d.in_ref = 1'b1;
                    c_d.st     = c_q.open ? ST_PRE : ST_RACT;
                end else if (req_valid) begin
                    c_d.row   = in_row;
                    c_d.col   = in_col;
                    c_d.wr    = req_write;
                    c_d.wdata = req_wdata;
                    if (c_q.open && (c_q.open_row == in_row))
                        c_d.st = ST_COL;
                    else if (c_q.open)
                        c_d.st = ST_PRE;
                    else
                        c_d.st = ST_ACT;
                end
            end
            ST_PRE: begin
                if (ph_last) begin
                    c_d.open = 1'b0;
                    c_d.st   = c_q.in_ref ? ST_RACT : ST_ACT;
                end
            end
            ST_ACT: begin
                if (ph_last) begin
                    c_d.open     = 1'b1;
                    c_d.open_row = c_q.row;
                    c_d.st       = ST_COL;
                end
            end
            ST_COL: begin
                if (ph_last) begin
                    if (!c_q.wr) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_data  = dr_rdata;
                    end
                    c_d.st = ST_IDLE;
                end
            end
            ST_RACT: begin
                if (ph_last)
                    c_d.st = ST_RPRE;
            end
            ST_RPRE: begin
                if (ph_last) begin
                    c_d.in_ref = 1'b0;
                    c_d.st     = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    assign ph_restart = (c_d.st != c_q.st);

    always_ff @(posedge clk) begin
        if (!rst_n)
            c_q <= '0;
        else
            c_q <= c_d;
    end

    always_comb begin
        unique case (c_q.st)
            ST_ACT:  dr_addr = c_q.row;
            ST_RACT: dr_addr = c_q.rrow;
            ST_COL:  dr_addr = c_q.col;
            default: dr_addr = c_q.open_row;
        endcase
    end

    assign dr_row_stb = (c_q.st == ST_ACT) || (c_q.st == ST_RACT);
    assign dr_col_stb = (c_q.st == ST_COL);
    assign dr_close   = (c_q.st == ST_PRE) || (c_q.st == ST_RPRE);
    assign dr_we      = (c_q.st == ST_COL) && c_q.wr;
    assign dr_wdata   = c_q.wdata;
    assign req_ready  = (c_q.st == ST_IDLE) && !ref_pend;
    assign rsp_valid  = c_q.rsp_valid;
    assign rsp_rdata  = c_q.rsp_data;

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dr_row_stb, dr_col_stb, dr_close}) <= 1); // R11
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((dr_row_stb && $past(dr_row_stb)) || (dr_col_stb && $past(dr_col_stb)))
        |-> $stable(dr_addr)); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        dr_col_stb |-> c_q.open); // R4
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(dr_row_stb || dr_col_stb || dr_close)); // R6
    AST_REF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RACT) |-> !c_q.open); // R10
    AST_NO_GRANT_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready); // R10

endmodule

// File: tb/pgdram_ctrl_tb.sv
module pgdram_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PIN_W      = 2;
    localparam int DATA_W     = 8;
    localparam int PH         = 2;
    localparam int REF        = 300;
    localparam int ROWS       = 1 << PIN_W;
    localparam int NVEC       = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [2*PIN_W-1:0]  req_addr = '0;
    logic                req_write = 1'b0;
    logic [DATA_W-1:0]   req_wdata = '0;
    logic                rsp_valid;
    logic [DATA_W-1:0]   rsp_rdata;
    logic [PIN_W-1:0]    dr_addr;
    logic                dr_row_stb, dr_col_stb, dr_close, dr_we;
    logic [DATA_W-1:0]   dr_wdata, dr_rdata;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgdram_ctrl #(
        .PIN_W(PIN_W), .DATA_W(DATA_W), .PHASE_CYC(PH), .REF_INTERVAL(REF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dr_addr(dr_addr),
        .dr_row_stb(dr_row_stb), .dr_col_stb(dr_col_stb), .dr_close(dr_close),
        .dr_we(dr_we), .dr_wdata(dr_wdata), .dr_rdata(dr_rdata)
    );

    // Behavioural memory: array plus one row buffer, acting on strobe rising edges.
    logic [DATA_W-1:0] arr [ROWS][ROWS];
    logic [DATA_W-1:0] rbuf [ROWS];
    logic [PIN_W-1:0]  act_row;
    logic              ras_p, cas_p, pre_p;
    int                ras_cnt, pre_cnt, cyc, ras_cyc;
    logic [PIN_W-1:0]  ras_addr;

    assign dr_rdata = rbuf[dr_addr];

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        ras_p <= dr_row_stb;
        cas_p <= dr_col_stb;
        pre_p <= dr_close;
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                rbuf[r] <= '0;
                for (int c = 0; c < ROWS; c++) arr[r][c] <= '0;
            end
            ras_cnt <= 0;
            pre_cnt <= 0;
            act_row <= '0;
        end else begin
            if (dr_row_stb && !ras_p) begin
                for (int c = 0; c < ROWS; c++) rbuf[c] <= arr[dr_addr][c];
                act_row  <= dr_addr;
                ras_cnt  <= ras_cnt + 1;
                ras_addr <= dr_addr;
                ras_cyc  <= cyc;
            end
            if (dr_close && !pre_p) begin
                for (int c = 0; c < ROWS; c++) arr[act_row][c] <= rbuf[c];
                pre_cnt <= pre_cnt + 1;
            end
            if (dr_col_stb && !cas_p && dr_we)
                rbuf[dr_addr] <= dr_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input logic [2*PIN_W-1:0] a,
                          input logic [DATA_W-1:0] wd, output int lat,
                          output logic [DATA_W-1:0] rd);
        bit saw;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        rd  = '0;
        if (!wr) begin
            while (!rsp_valid) begin
                @(negedge clk);
                lat++;
            end
            rd = rsp_rdata;
        end else begin
            saw = 1'b0;
            while (!req_ready) begin
                if (rsp_valid) saw = 1'b1;
                @(negedge clk);
                lat++;
            end
            check(!saw, "R7 write gives no rsp_valid", int'(saw), 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_ras();
        int c0;
        c0 = ras_cnt;
        while (ras_cnt == c0) @(negedge clk);
    endtask

    // {write, addr[3:0], wdata[7:0], expected read[7:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 4'h5, 8'hA1, 8'h00},
        {1'b1, 4'h6, 8'hB2, 8'h00},
        {1'b0, 4'h5, 8'h00, 8'hA1},
        {1'b0, 4'h6, 8'h00, 8'hB2},
        {1'b1, 4'hC, 8'hC3, 8'h00},
        {1'b0, 4'h5, 8'h00, 8'hA1},
        {1'b0, 4'hC, 8'h00, 8'hC3},
        {1'b1, 4'h0, 8'h11, 8'h00},
        {1'b1, 4'hF, 8'hFF, 8'h00},
        {1'b0, 4'h0, 8'h00, 8'h11},
        {1'b0, 4'hF, 8'h00, 8'hFF},
        {1'b0, 4'h6, 8'h00, 8'hB2}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat, r0, p0;
        int stamps [5];
        int addrs  [5];
        logic [DATA_W-1:0] rd;

        do_reset();
        // R1 reset state
        check(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check({dr_row_stb, dr_col_stb, dr_close} === 3'b000, "R1 strobes low",
              int'({dr_row_stb, dr_col_stb, dr_close}), 0);
        check(rsp_valid === 1'b0, "R1 rsp_valid low", int'(rsp_valid), 0);

        // R3 first access with no open row: row 2, column 1
        r0 = ras_cnt;
        do_req(1'b0, 4'h9, 8'h00, lat, rd);
        check(lat == 2*PH, "R3 closed-row read latency", lat, 2*PH);
        check(ras_cnt - r0 == 1, "R3 one row strobe", ras_cnt - r0, 1);
        check(ras_addr == 2, "R2 row bits on pins at row strobe", int'(ras_addr), 2);
        check(rd == 8'h00, "R7 read of cleared array", int'(rd), 0);

        // R8 / R4 write and read inside the open row
        r0 = ras_cnt;
        p0 = pre_cnt;
        do_req(1'b1, 4'hA, 8'h3C, lat, rd);
        check(lat == PH, "R6 write hit phase length", lat, PH);
        do_req(1'b0, 4'hA, 8'h00, lat, rd);
        check(lat == PH, "R4 open-row read latency", lat, PH);
        check(rd == 8'h3C, "R8 read back written value", int'(rd), 8'h3C);
        check(ras_cnt == r0 && pre_cnt == p0, "R4 no row or close strobe on hit",
              (ras_cnt - r0) + (pre_cnt - p0), 0);
        do_req(1'b0, 4'h9, 8'h00, lat, rd);
        check(rd == 8'h00, "R8 neighbour column untouched", int'(rd), 0);

        // R5 row miss with an open row
        p0 = pre_cnt;
        do_req(1'b0, 4'h1, 8'h00, lat, rd);
        check(lat == 3*PH, "R5 row-miss latency", lat, 3*PH);
        check(pre_cnt - p0 == 1, "R5 close before new row", pre_cnt - p0, 1);
        do_req(1'b0, 4'hA, 8'h00, lat, rd);
        check(rd == 8'h3C, "R5 written row kept after close", int'(rd), 8'h3C);
        check(lat == 3*PH, "R5 reopen latency", lat, 3*PH);

        // Vector table walk (R2, R7, R8, R5)
        for (int i = 0; i < NVEC; i++) begin
            do_req(VEC[i][20], VEC[i][19:16], VEC[i][15:8], lat, rd);
            if (!VEC[i][20])
                check(rd == VEC[i][7:0], "R8 vector read data", int'(rd), int'(VEC[i][7:0]));
        end

        // R9 refresh cadence and row order while idle
        do_reset();
        check(req_ready === 1'b1, "R1 ready after second reset", int'(req_ready), 1);
        for (int k = 0; k < 5; k++) begin
            wait_ras();
            stamps[k] = ras_cyc;
            addrs[k]  = int'(ras_addr);
        end
        for (int k = 0; k < 5; k++)
            check(addrs[k] == (k % ROWS), "R9 refresh row order", addrs[k], k % ROWS);
        for (int k = 1; k < 5; k++)
            check(stamps[k] - stamps[k-1] == REF, "R9 refresh interval",
                  stamps[k] - stamps[k-1], REF);
        repeat (2*PH + 2) @(negedge clk);
        check(pre_cnt == ras_cnt, "R9 each refresh closes its row", pre_cnt, ras_cnt);

        // R10 refresh closes an open row and keeps its data
        do_req(1'b1, 4'h9, 8'h5A, lat, rd);
        p0 = pre_cnt;
        r0 = ras_cnt;
        wait_ras();
        repeat (2*PH + 2) @(negedge clk);
        check(pre_cnt - p0 == 2, "R10 open row closed then refresh closed",
              pre_cnt - p0, 2);
        check(ras_cnt - r0 == 1, "R10 one refresh row strobe", ras_cnt - r0, 1);
        do_req(1'b0, 4'h9, 8'h00, lat, rd);
        check(lat == 2*PH, "R10 access after refresh reopens row", lat, 2*PH);
        check(rd == 8'h5A, "R10 data survives refresh", int'(rd), 8'h5A);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule